// File: doc/BRIEF.md
# Four-Channel Clock Synthesizer Control Register Block

This block holds the software-visible configuration of a clock synthesizer with four output channels that share one multiplying PLL. A simple write-strobe bus with a combinational read port reaches a main control word, a PLL multiplier word, a program-enable word and one parameter word per channel. The main control word carries the per-channel reset and standby bits, the PLL power-down bit and a read-only lock flag sampled from the analog side. The multiplier word drives the PLL's multiply factor.

Each channel keeps its fine-phase, coarse-divider and output-divider settings twice. Software writes a staging copy. An active copy drives the synthesizer datapath. The active copy changes only when software clears that channel's program-enable bit after setting it. All three fields then move across together on one clock edge, so a running clock can be retuned without ever seeing a half-written set of values. The divide-by-three select is not double-buffered. It reaches the datapath as soon as it is written.

Top module: `qfs_synth_regs`

## Requirements
- R1: After reset, the main control word reads 0x00001F0F: bits 3:0 hold every channel in reset, bits 11:8 hold every channel in standby, bit 12 keeps the PLL powered down and the lock flag is 0. The multiplier and program-enable words read 0, `pll_mult` is 16, every `chan_unprog` bit is 1 and every `chan_div3` bit is 0.
- R2: The multiplier word keeps only bits 18:16 and reads every other bit as 0. `pll_mult` equals that 3-bit field plus 16, giving a range of 16 to 23.
- R3: In the main control word, bit c of 3:0 drives `chan_rst[c]` with 1 meaning reset. Bit 8+c drives `chan_stby[c]` with 1 meaning standby. Bit 12 set to 0 makes `pll_pwr_on` 1, and bit 12 set to 1 powers the PLL down.
- R4: Bit 24 of the main control word reads the value `pll_lock_in` had at the previous clock edge. Writes to that bit have no effect.
- R5: A channel parameter word reads back its staging value, with the fine phase at bits 14:0, the coarse divider at bits 19:15, the output-divider select at bits 23:20 and the divide-by-three control at bit 24. Bits 31:25 read as 0. After reset the word reads 0x01000000.
- R6: While a channel's program-enable bit does not fall, writes to its staging fields leave `chan_phase`, `chan_coarse` and `chan_odiv` for that channel unchanged. This covers writes made while the bit is held at 1.
- R7: A write to the program-enable word (bit c for channel c) that takes a bit from 1 to 0 copies that channel's staging phase, coarse and output-divider values to its outputs on that same clock edge. A write that raises the bit, or that writes 0 over 0, copies nothing, and other channels are not affected.
- R8: The divide-by-three control is active low and is not double-buffered. On the edge that writes a parameter word, `chan_div3[c]` becomes the inverse of bit 24.
- R9: `chan_unprog[c]` is 1 exactly when the active phase, coarse and output-divider values of channel c are all zero.
- R10: The parameter words of channels 0 to 3 sit at offsets 0x10, 0x14, 0x18 and 0x1C. The main control, multiplier and program-enable words sit at 0x00, 0x04 and 0x08. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | ADDR_W | Byte offset of the word being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pll_lock_in | input | 1 | Lock indication from the PLL |
| pll_mult | output | 5 | Effective PLL multiply factor |
| pll_pwr_on | output | 1 | 1 when the PLL is powered up |
| chan_rst | output | NUM_CH | Per-channel reset, 1 = held in reset |
| chan_stby | output | NUM_CH | Per-channel standby, 1 = standby |
| chan_div3 | output | NUM_CH | Per-channel divide-by-three enable |
| chan_phase | output | NUM_CH*15 | Active fine-phase values, channel c at [15c+14:15c] |
| chan_coarse | output | NUM_CH*5 | Active coarse divider values, channel c at [5c+4:5c] |
| chan_odiv | output | NUM_CH*4 | Active output-divider selects, channel c at [4c+3:4c] |
| chan_unprog | output | NUM_CH | 1 when a channel's active tuning is all zero |

## Verification
The assertions assume the bus is single-ported: at most one word is written per cycle, and the address is held stable around the sampling edge. The hold check on the active tuning outputs relies on this, because it treats any cycle without a write to the program-enable offset as a cycle in which nothing may move. The lock check assumes `pll_lock_in` is already synchronous to the control clock. The stimulus drives every input only on the falling clock edge, issues one write at a time, and changes the lock input only between accesses.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

    localparam int DATA_W    = 32;

    // Parameter word layout
    localparam int PHASE_W   = 15;
    localparam int COARSE_W  = 5;
    localparam int ODIV_W    = 4;
    localparam int PHASE_LSB = 0;
    localparam int COARSE_LSB = PHASE_LSB + PHASE_W;
    localparam int ODIV_LSB  = COARSE_LSB + COARSE_W;
    localparam int DIV3N_BIT = ODIV_LSB + ODIV_W;

    // Main control word layout
    localparam int RST_LSB   = 0;
    localparam int STBY_LSB  = 8;
    localparam int PWRDN_BIT = 12;
    localparam int LOCK_BIT  = 24;

    // Multiplier word layout
    localparam int MULT_LSB  = 16;
    localparam int MULT_W    = 3;
    localparam int MULT_BASE = 16;
    localparam int FACTOR_W  = 5;

    // Offsets
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_PLL   = 'h04;
    localparam int OFS_PROG  = 'h08;
    localparam int OFS_PARAM = 'h10;

    typedef struct packed {
        logic [ODIV_W-1:0]   odiv;
        logic [COARSE_W-1:0] coarse;
        logic [PHASE_W-1:0]  phase;
    } tune_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PLL,
        SEL_PROG,
        SEL_PARAM
    } reg_sel_e;

    function automatic tune_t tune_from_word(input logic [DATA_W-1:0] w);
        tune_t t;
        t.phase  = w[PHASE_LSB  +: PHASE_W];
        t.coarse = w[COARSE_LSB +: COARSE_W];
        t.odiv   = w[ODIV_LSB   +: ODIV_W];
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] word_from_tune(input tune_t t, input logic div3n);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PHASE_LSB  +: PHASE_W]  = t.phase;
        w[COARSE_LSB +: COARSE_W] = t.coarse;
        w[ODIV_LSB   +: ODIV_W]   = t.odiv;
        w[DIV3N_BIT]              = div3n;
        return w;
    endfunction

    function automatic logic tune_is_zero(input tune_t t);
        return (t.phase == '0) && (t.coarse == '0) && (t.odiv == '0);
    endfunction

endpackage

// File: rtl/qfs_addr_dec.sv
module qfs_addr_dec
    import qfs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] chan_idx
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PLL   = ADDR_W'(OFS_PLL);
    localparam logic [ADDR_W-1:0] A_PROG  = ADDR_W'(OFS_PROG);
    localparam logic [ADDR_W-1:0] A_PBASE = ADDR_W'(OFS_PARAM);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PARAM + 4 * NUM_CH);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel      = addr - A_PBASE;
        chan_idx = rel[2 +: CH_W];
        sel      = SEL_NONE;
        if (addr == A_CTRL) begin
            sel = SEL_CTRL;
        end else if (addr == A_PLL) begin
            sel = SEL_PLL;
        end else if (addr == A_PROG) begin
            sel = SEL_PROG;
        end else if ((addr >= A_PBASE) && (addr < A_PEND) && (addr[1:0] == 2'b00)) begin
            sel = SEL_PARAM;
        end
    end

endmodule

// File: rtl/qfs_ctrl_regs.sv
module qfs_ctrl_regs
    import qfs_pkg::*;
#(
    parameter int   NUM_CH    = 4,
    parameter logic STBY_POL  = 1'b1,
    parameter logic PWRUP_POL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_pll,
    input  logic              wr_prog,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_in,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] pll_word,
    output logic [DATA_W-1:0] prog_word,
    output logic [NUM_CH-1:0] commit,
    output logic [NUM_CH-1:0] rst_bits,
    output logic [NUM_CH-1:0] stby_bits,
    output logic              pwrdn_bit,
    output logic [MULT_W-1:0] mult_field
);
    // Reset state: channels held in reset and standby, PLL powered down
    localparam logic [NUM_CH-1:0] STBY_RST  = STBY_POL ? '1 : '0;
    localparam logic              PWRDN_RST = PWRUP_POL;

    logic [NUM_CH-1:0] rst_q;
    logic [NUM_CH-1:0] stby_q;
    logic              pwrdn_q;
    logic [MULT_W-1:0] mult_q;
    logic [NUM_CH-1:0] prog_q;
    logic              lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_q   <= '1;
            stby_q  <= STBY_RST;
            pwrdn_q <= PWRDN_RST;
            mult_q  <= '0;
            prog_q  <= '0;
            lock_q  <= 1'b0;
        end else begin
            lock_q <= lock_in;
            if (wr_ctrl) begin
                rst_q   <= wdata[RST_LSB  +: NUM_CH];
                stby_q  <= wdata[STBY_LSB +: NUM_CH];
                pwrdn_q <= wdata[PWRDN_BIT];
            end
            if (wr_pll) begin
                mult_q <= wdata[MULT_LSB +: MULT_W];
            end
            if (wr_prog) begin
                prog_q <= wdata[NUM_CH-1:0];
            end
        end
    end

    // A channel commits on the edge where its enable bit is written from 1 to 0
    assign commit = {NUM_CH{wr_prog}} & prog_q & ~wdata[NUM_CH-1:0];

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[RST_LSB  +: NUM_CH]   = rst_q;
        ctrl_word[STBY_LSB +: NUM_CH]   = stby_q;
        ctrl_word[PWRDN_BIT]            = pwrdn_q;
        ctrl_word[LOCK_BIT]             = lock_q;
        pll_word                        = '0;
        pll_word[MULT_LSB +: MULT_W]    = mult_q;
        prog_word                       = '0;
        prog_word[NUM_CH-1:0]           = prog_q;
    end

    assign rst_bits   = rst_q;
    assign stby_bits  = stby_q;
    assign pwrdn_bit  = pwrdn_q;
    assign mult_field = mult_q;

endmodule

// File: rtl/qfs_chan_slot.sv
module qfs_chan_slot
    import qfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stage,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output logic [DATA_W-1:0] stage_word,
    output tune_t             active,
    output logic              div3_en,
    output logic              unprog
);
    tune_t stage_q;
    tune_t active_q;
    logic  div3n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            div3n_q  <= 1'b1;
            active_q <= '0;
        end else begin
            if (wr_stage) begin
                stage_q <= tune_from_word(wdata);
                div3n_q <= wdata[DIV3N_BIT];
            end
            if (commit) begin
                active_q <= stage_q;
            end
        end
    end

    assign stage_word = word_from_tune(stage_q, div3n_q);
    assign active     = active_q;
    assign div3_en    = ~div3n_q;
    assign unprog     = tune_is_zero(active_q);

endmodule

// File: rtl/qfs_synth_regs.sv
module qfs_synth_regs
    import qfs_pkg::*;
#(
    parameter int   NUM_CH    = 4,
    parameter int   ADDR_W    = 6,
    parameter logic STBY_POL  = 1'b1,
    parameter logic PWRUP_POL = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic                         pll_lock_in,
    output logic [4:0]                   pll_mult,
    output logic                         pll_pwr_on,
    output logic [NUM_CH-1:0]            chan_rst,
    output logic [NUM_CH-1:0]            chan_stby,
    output logic [NUM_CH-1:0]            chan_div3,
    output logic [NUM_CH*15-1:0]         chan_phase,
    output logic [NUM_CH*5-1:0]          chan_coarse,
    output logic [NUM_CH*4-1:0]          chan_odiv,
    output logic [NUM_CH-1:0]            chan_unprog
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_sel_e          sel;
    logic [CH_W-1:0]   chan_idx;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] pll_word;
    logic [DATA_W-1:0] prog_word;
    logic [NUM_CH-1:0] commit;
    logic [NUM_CH-1:0] rst_bits;
    logic [NUM_CH-1:0] stby_bits;
    logic              pwrdn_bit;
    logic [MULT_W-1:0] mult_field;
    logic [DATA_W-1:0] stage_words [NUM_CH];
    tune_t             active      [NUM_CH];

    qfs_addr_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) dec_i (
        .addr     (bus_addr),
        .sel      (sel),
        .chan_idx (chan_idx)
    );

    qfs_ctrl_regs #(
        .NUM_CH    (NUM_CH),
        .STBY_POL  (STBY_POL),
        .PWRUP_POL (PWRUP_POL)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (bus_wr && (sel == SEL_CTRL)),
        .wr_pll     (bus_wr && (sel == SEL_PLL)),
        .wr_prog    (bus_wr && (sel == SEL_PROG)),
        .wdata      (bus_wdata),
        .lock_in    (pll_lock_in),
        .ctrl_word  (ctrl_word),
        .pll_word   (pll_word),
        .prog_word  (prog_word),
        .commit     (commit),
        .rst_bits   (rst_bits),
        .stby_bits  (stby_bits),
        .pwrdn_bit  (pwrdn_bit),
        .mult_field (mult_field)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        qfs_chan_slot slot_i (
            .clk        (clk),
            .rst        (rst),
            .wr_stage   (bus_wr && (sel == SEL_PARAM) && (chan_idx == CH_W'(c))),
            .wdata      (bus_wdata),
            .commit     (commit[c]),
            .stage_word (stage_words[c]),
            .active     (active[c]),
            .div3_en    (chan_div3[c]),
            .unprog     (chan_unprog[c])
        );
        assign chan_phase [c*PHASE_W  +: PHASE_W]  = active[c].phase;
        assign chan_coarse[c*COARSE_W +: COARSE_W] = active[c].coarse;
        assign chan_odiv  [c*ODIV_W   +: ODIV_W]   = active[c].odiv;
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  bus_rdata = ctrl_word;
            SEL_PLL:   bus_rdata = pll_word;
            SEL_PROG:  bus_rdata = prog_word;
            SEL_PARAM: bus_rdata = stage_words[chan_idx];
            default:   bus_rdata = '0;
        endcase
    end

    assign pll_mult   = FACTOR_W'(mult_field) + FACTOR_W'(MULT_BASE);
    assign pll_pwr_on = PWRUP_POL ? ~pwrdn_bit : pwrdn_bit;
    assign chan_stby  = STBY_POL ? stby_bits : ~stby_bits;
    assign chan_rst   = rst_bits;

endmodule

// File: rtl/qfs_synth_regs_chk.sv
module qfs_synth_regs_chk
    import qfs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 pll_lock_in,
    input logic [4:0]           pll_mult,
    input logic [NUM_CH-1:0]    chan_div3,
    input logic [NUM_CH*15-1:0] chan_phase,
    input logic [NUM_CH*5-1:0]  chan_coarse,
    input logic [NUM_CH*4-1:0]  chan_odiv
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PLL   = ADDR_W'(OFS_PLL);
    localparam logic [ADDR_W-1:0] A_PROG  = ADDR_W'(OFS_PROG);
    localparam logic [ADDR_W-1:0] A_PBASE = ADDR_W'(OFS_PARAM);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PARAM + 4 * NUM_CH);

    logic mapped;
    assign mapped = (bus_addr == A_CTRL) || (bus_addr == A_PLL) || (bus_addr == A_PROG) ||
                    ((bus_addr >= A_PBASE) && (bus_addr < A_PEND) && (bus_addr[1:0] == 2'b00));

    // R2: multiply factor always lies in the 16..23 window
    p_mult_window_r2: assert property (@(posedge clk) disable iff (rst)
        (pll_mult >= 5'd16) && (pll_mult <= 5'd23))
        else $error("p_mult_window_r2");

    // R4: lock flag mirrors the lock input one edge later
    p_lock_sample_r4: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == A_CTRL) && !$past(rst)) |-> (bus_rdata[LOCK_BIT] == $past(pll_lock_in)))
        else $error("p_lock_sample_r4");

    // R6: without a program-enable write the active tuning cannot move
    p_active_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == A_PROG)) |=>
            ($stable(chan_phase) && $stable(chan_coarse) && $stable(chan_odiv)))
        else $error("p_active_hold_r6");

    // R10: unmapped offsets read as zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (bus_rdata == 32'h0))
        else $error("p_unmapped_zero_r10");

    // R8: divide-by-three select follows the written control bit at once
    for (genvar c = 0; c < NUM_CH; c++) begin : g_div3
        p_div3_direct_r8: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && (bus_addr == ADDR_W'(OFS_PARAM + 4 * c))) |=>
                (chan_div3[c] == !$past(bus_wdata[DIV3N_BIT])))
            else $error("p_div3_direct_r8");
    end

endmodule

bind qfs_synth_regs qfs_synth_regs_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pll_lock_in (pll_lock_in),
    .pll_mult    (pll_mult),
    .chan_div3   (chan_div3),
    .chan_phase  (chan_phase),
    .chan_coarse (chan_coarse),
    .chan_odiv   (chan_odiv)
);

// File: tb/qfs_synth_regs_tb_top.sv
module qfs_synth_regs_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 6;

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 18;
    // rd=1: read and compare with data; rd=0: write data
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h00, 32'h0000_1F0F, 4'd1},  // R1 control reset value
        '{1'b1, 8'h04, 32'h0000_0000, 4'd1},  // R1 multiplier reset
        '{1'b1, 8'h08, 32'h0000_0000, 4'd1},  // R1 program-enable reset
        '{1'b0, 8'h04, 32'hFFFF_FFFF, 4'd2},
        '{1'b1, 8'h04, 32'h0007_0000, 4'd2},  // R2 only 18:16 kept
        '{1'b0, 8'h00, 32'hFFFF_FFFF, 4'd4},
        '{1'b1, 8'h00, 32'h0000_1F0F, 4'd4},  // R4 lock bit not writable
        '{1'b0, 8'h00, 32'h0000_0000, 4'd3},
        '{1'b1, 8'h00, 32'h0000_0000, 4'd3},  // R3 all cleared
        '{1'b0, 8'h14, 32'hFFFF_FFFF, 4'd5},
        '{1'b1, 8'h14, 32'h01FF_FFFF, 4'd5},  // R5 staging readback
        '{1'b1, 8'h10, 32'h0100_0000, 4'd5},  // R5 staging reset
        '{1'b1, 8'h0C, 32'h0000_0000, 4'd10}, // R10 hole
        '{1'b1, 8'h20, 32'h0000_0000, 4'd10}, // R10 past last channel
        '{1'b1, 8'h3C, 32'h0000_0000, 4'd10}, // R10 top
        '{1'b0, 8'h1C, 32'h00AB_CDEF, 4'd10},
        '{1'b1, 8'h1C, 32'h00AB_CDEF, 4'd10}, // R10 channel 3 offset
        '{1'b1, 8'h18, 32'h0100_0000, 4'd10}  // R10 channel 2 untouched
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              pll_lock_in = 1'b0;
    logic [4:0]        pll_mult;
    logic              pll_pwr_on;
    logic [NCH-1:0]    chan_rst;
    logic [NCH-1:0]    chan_stby;
    logic [NCH-1:0]    chan_div3;
    logic [NCH*15-1:0] chan_phase;
    logic [NCH*5-1:0]  chan_coarse;
    logic [NCH*4-1:0]  chan_odiv;
    logic [NCH-1:0]    chan_unprog;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    qfs_synth_regs #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pll_lock_in (pll_lock_in),
        .pll_mult    (pll_mult),
        .pll_pwr_on  (pll_pwr_on),
        .chan_rst    (chan_rst),
        .chan_stby   (chan_stby),
        .chan_div3   (chan_div3),
        .chan_phase  (chan_phase),
        .chan_coarse (chan_coarse),
        .chan_odiv   (chan_odiv),
        .chan_unprog (chan_unprog)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_tune(input string tag, input int c, input logic [14:0] ph,
                              input logic [4:0] co, input logic [3:0] od);
        check(tag, {17'b0, chan_phase[c*15 +: 15]}, {17'b0, ph});
        check(tag, {27'b0, chan_coarse[c*5 +: 5]}, {27'b0, co});
        check(tag, {28'b0, chan_odiv[c*4 +: 4]}, {28'b0, od});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset outputs
        check("R1 pll_mult", {27'b0, pll_mult}, 32'd16);
        check("R1 pll_pwr_on", {31'b0, pll_pwr_on}, 32'd0);
        check("R1 chan_stby", {28'b0, chan_stby}, 32'hF);
        check("R1 chan_rst", {28'b0, chan_rst}, 32'hF);
        check("R1 chan_unprog", {28'b0, chan_unprog}, 32'hF);
        check("R1 chan_div3", {28'b0, chan_div3}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].rd) begin
                rd(VECS[i].addr[AW-1:0], r);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].data);
            end else begin
                wr(VECS[i].addr[AW-1:0], VECS[i].data);
            end
        end

        // R2 factor after field 7
        check("R2 pll_mult", {27'b0, pll_mult}, 32'd23);
        // R3 control cleared: PLL up, channels running and out of reset
        check("R3 pll_pwr_on", {31'b0, pll_pwr_on}, 32'd1);
        check("R3 chan_stby", {28'b0, chan_stby}, 32'h0);
        check("R3 chan_rst", {28'b0, chan_rst}, 32'h0);
        wr(6'h00, 32'h0000_1A05);
        check("R3 mixed stby", {28'b0, chan_stby}, 32'hA);
        check("R3 mixed rst", {28'b0, chan_rst}, 32'h5);
        check("R3 power down", {31'b0, pll_pwr_on}, 32'd0);

        // R4 lock sampling
        @(negedge clk);
        pll_lock_in = 1'b1;
        @(negedge clk);
        rd(6'h00, r);
        check("R4 lock high", {31'b0, r[24]}, 32'd1);
        pll_lock_in = 1'b0;
        @(negedge clk);
        rd(6'h00, r);
        check("R4 lock low", {31'b0, r[24]}, 32'd0);

        // R8 channel 1 staging has bit 24 set; channel 3 has it clear
        check("R8 div3 bypass ch1", {31'b0, chan_div3[1]}, 32'd0);
        check("R8 div3 on ch3", {31'b0, chan_div3[3]}, 32'd1);

        // R7 rising program-enable bit copies nothing
        wr(6'h08, 32'h0000_0002);
        check_tune("R7 rise no copy", 1, 15'h0, 5'h0, 4'h0);
        // R7 falling bit copies all fields of channel 1 only
        wr(6'h08, 32'h0000_0000);
        check_tune("R7 fall copy ch1", 1, 15'h7FFF, 5'h1F, 4'hF);
        check_tune("R7 ch3 untouched", 3, 15'h0, 5'h0, 4'h0);
        check("R9 ch1 programmed", {31'b0, chan_unprog[1]}, 32'd0);
        check("R9 ch3 unprogrammed", {31'b0, chan_unprog[3]}, 32'd1);

        // R6 staging edit with bit low does not reach outputs; R8 applies at once
        wr(6'h14, 32'h00C5_4321);
        check_tune("R6 edit bit low", 1, 15'h7FFF, 5'h1F, 4'hF);
        check("R8 div3 immediate", {31'b0, chan_div3[1]}, 32'd1);
        wr(6'h08, 32'h0000_0002);
        wr(6'h14, 32'h00C5_4321);
        check_tune("R6 edit bit high", 1, 15'h7FFF, 5'h1F, 4'hF);
        wr(6'h08, 32'h0000_0000);
        check_tune("R7 second commit", 1, 15'h4321, 5'h0A, 4'hC);

        // R7 writing 0 over 0 copies nothing
        wr(6'h14, 32'h0100_0000);
        wr(6'h08, 32'h0000_0000);
        check_tune("R7 zero over zero", 1, 15'h4321, 5'h0A, 4'hC);
        check("R9 still programmed", {31'b0, chan_unprog[1]}, 32'd0);

        // R9 committing all-zero tuning marks channel unprogrammed
        wr(6'h08, 32'h0000_0002);
        wr(6'h08, 32'h0000_0000);
        check("R9 zero commit", {31'b0, chan_unprog[1]}, 32'd1);
        check_tune("R9 zero tuning", 1, 15'h0, 5'h0, 4'h0);

        // R7 channel 3 alone, channel 1 stays zero
        wr(6'h1C, 32'h0000_0007);
        wr(6'h08, 32'h0000_0008);
        rd(6'h08, r);
        check("R7 enable readback", r, 32'h0000_0008);
        wr(6'h08, 32'h0000_0000);
        check_tune("R7 ch3 commit", 3, 15'h0007, 5'h0, 4'h0);
        check("R9 ch3 nonzero phase", {31'b0, chan_unprog[3]}, 32'd0);
        check("R9 ch1 unaffected", {31'b0, chan_unprog[1]}, 32'd1);

        finish_run();
    end

endmodule